// File: doc/BRIEF.md
# Banked Scratchpad Read Path with Conflict Serialization

This block is the read side of a local scratchpad shared by a group of parallel lanes. A whole group of lane requests is offered at once: each lane carries a word address and an active bit. The scratchpad is split into several single-port banks, interleaved on the low bits of the word address. The block works out which bank each lane needs. It serves every bank in parallel, one distinct word per bank per cycle. Lanes that ask for the same word are merged into one bank read whose result is copied to all of them.

The group is therefore served in as many bank cycles as the busiest bank needs, counting distinct words only. While the group is in progress the requester is stalled: no new group is taken in. When the last bank read has returned, every lane's result is presented at once together with a one-cycle completion pulse.

The request side is a valid/ready stream. A group transfers on a rising clock edge where `grp_valid` and `grp_ready` are both high. `grp_ready` falls on the edge that accepts a group and stays low through the completion cycle. It rises again the cycle after `rsp_done`. While ready is low the request inputs are ignored. The response side has no back-pressure: the result is announced by `rsp_done` and stays on `rsp_data` until the next group is accepted. The scratchpad contents are fixed at power-up by a formula of the address, since writes are not part of this block.

Top module: `lane_bank_scratch`

## Requirements
- R1: Bank mapping and contents. With 8 banks, a word address `a` (10 bits) lives in bank `a[2:0]`, row `a[9:3]`. Reading it returns `{16'h5A5A ^ a, a*3}`, where `a` is zero-extended to 16 bits and the product is truncated to 16 bits.
- R2: If all active lanes of a group use different banks, `rsp_done` is high in the cycle that begins 2 rising edges after the accepting edge.
- R3: Let K be the largest number of distinct addresses that the active lanes send to any one bank. With K >= 1, `rsp_done` is high in the cycle that begins K+1 rising edges after the accepting edge.
- R4: Lanes of a group that request the same address are served by one bank read. They add 1, not their number, to that bank's count, and each of them receives the word.
- R5: A lane whose bit in `grp_active` is 0 adds nothing to any bank's count, and its 32-bit field of `rsp_data` is zero in the completion cycle.
- R6: `grp_ready` is high after reset. It is low from the accepting edge through the completion cycle and high again in the cycle after `rsp_done`. Valid requests offered while it is low are ignored and change neither the pending result nor its timing.
- R7: `rsp_done` is a single-cycle pulse, one per accepted group. All active lanes' data is valid on `rsp_data` during that cycle, with lane `i` in bits `[32*i+31:32*i]`.
- R8: A group with no active lane still completes, with `rsp_done` high 2 rising edges after the accepting edge and all data zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 1 | A request group is offered |
| grp_ready | output | 1 | Block can accept a group this cycle |
| grp_active | input | 8 | Per-lane request enable, bit i for lane i |
| grp_addr | input | 80 | Lane word addresses, lane i in bits [10*i+9:10*i] |
| rsp_done | output | 1 | One-cycle pulse: group finished, data valid |
| rsp_data | output | 256 | Lane read data, lane i in bits [32*i+31:32*i] |

## Verification
The result of a group is due max(K,1)+1 rising edges after the accepting edge, where K is the bank load in distinct words. The driver computes that figure from the lane addresses and mask on its own. It turns the figure into an absolute cycle number and queues it with the expected per-lane words. The monitor samples on the falling edge. When it sees `rsp_done`, it compares the current cycle number, every lane's word and `grp_ready` against the queued item. One cycle later it checks that the pulse has ended and ready is back. Patterns cover conflict-free, strided, fully serialized, broadcast, masked, empty and pseudo-random groups, plus requests offered while the block is stalled.

// File: rtl/scratch_pkg.sv
package scratch_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } grp_state_t;

  // Power-up contents of any scratchpad word, a function of its global address (R1)
  function automatic logic [WORD_W-1:0] word_init(input logic [15:0] a);
    logic [15:0] lo;
    lo = a * 16'd3;
    return {16'h5A5A ^ a, lo};
  endfunction

endpackage

// File: rtl/bank_ram.sv
module bank_ram
  import scratch_pkg::*;
#(
  parameter int ROW_W   = 7,
  parameter int BANK_W  = 3,
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [WORD_W-1:0] rd_word
);
  localparam int ROWS = 1 << ROW_W;

  logic [WORD_W-1:0] mem [ROWS];

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      mem[r] = word_init(16'((r << BANK_W) | BANK_ID));
    end
  end

  // One-cycle synchronous read; output holds when not enabled
  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= mem[rd_row];
  end

endmodule

// File: rtl/bank_arbiter.sv
module bank_arbiter #(
  parameter int LANES   = 8,
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 7,
  parameter int BANK_ID = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             pending,
  input  logic [LANES-1:0][BANK_W-1:0] lane_bank,
  input  logic [LANES-1:0][ROW_W-1:0]  lane_row,
  output logic                         rd_en,
  output logic [ROW_W-1:0]             rd_row,
  output logic [LANES-1:0]             serve
);
  logic [LANES-1:0] cand;
  logic             found;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      cand[l] = pending[l] && (lane_bank[l] == BANK_W'(BANK_ID));
    end
  end

  // Lowest-index waiting lane picks this cycle's row
  always_comb begin
    found  = 1'b0;
    rd_row = '0;
    for (int l = 0; l < LANES; l++) begin
      if (cand[l] && !found) begin
        found  = 1'b1;
        rd_row = lane_row[l];
      end
    end
  end

  assign rd_en = found;

  // Every waiting lane on the same row rides the same read (broadcast)
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      serve[l] = cand[l] && (lane_row[l] == rd_row);
    end
  end

  // R4
  bank_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != '0 && rd_en) |-> (serve != '0));

endmodule

// File: rtl/lane_bank_scratch.sv
module lane_bank_scratch
  import scratch_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int BANKS  = 8,
  parameter int ADDR_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     grp_valid,
  output logic                     grp_ready,
  input  logic [LANES-1:0]         grp_active,
  input  logic [LANES*ADDR_W-1:0]  grp_addr,
  output logic                     rsp_done,
  output logic [LANES*WORD_W-1:0]  rsp_data
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;

  grp_state_t                   state_q;
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0]             pend_q;
  logic [LANES-1:0]             srv_q;
  logic [LANES-1:0][WORD_W-1:0] data_q;

  logic [LANES-1:0][BANK_W-1:0] lane_bank;
  logic [LANES-1:0][ROW_W-1:0]  lane_row;
  logic [BANKS-1:0][LANES-1:0]  bank_serve;
  logic [BANKS-1:0][WORD_W-1:0] bank_word;
  logic [LANES-1:0]             serve_all;
  logic [LANES-1:0]             pend_next;
  logic                         accept;

  // R1: low address bits select the bank, the rest the row
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lane_bank[l] = addr_q[l][BANK_W-1:0];
      lane_row[l]  = addr_q[l][ADDR_W-1:BANK_W];
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             rd_en;
    logic [ROW_W-1:0] rd_row;

    bank_arbiter #(
      .LANES(LANES), .BANK_W(BANK_W), .ROW_W(ROW_W), .BANK_ID(b)
    ) u_arb (
      .clk(clk), .rst_n(rst_n), .pending(pend_q),
      .lane_bank(lane_bank), .lane_row(lane_row),
      .rd_en(rd_en), .rd_row(rd_row), .serve(bank_serve[b])
    );

    bank_ram #(
      .ROW_W(ROW_W), .BANK_W(BANK_W), .BANK_ID(b)
    ) u_ram (
      .clk(clk), .rd_en(rd_en), .rd_row(rd_row), .rd_word(bank_word[b])
    );
  end

  always_comb begin
    serve_all = '0;
    for (int b = 0; b < BANKS; b++) serve_all = serve_all | bank_serve[b];
  end

  assign pend_next = pend_q & ~serve_all;
  assign accept    = grp_valid && grp_ready;
  assign grp_ready = (state_q == ST_IDLE);
  assign rsp_done  = (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pend_q  <= '0;
      srv_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          srv_q <= '0;
          if (grp_valid) begin
            for (int l = 0; l < LANES; l++) addr_q[l] <= grp_addr[l*ADDR_W +: ADDR_W];
            pend_q  <= grp_active;
            state_q <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          pend_q <= pend_next;
          srv_q  <= serve_all;
          if (pend_next == '0) state_q <= ST_FLUSH;
        end
        ST_FLUSH: begin
          srv_q   <= '0;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Read data lands one cycle after its bank slot; cleared on acceptance (R5)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (accept) begin
      data_q <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (srv_q[l]) data_q[l] <= bank_word[lane_bank[l]];
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) rsp_data[l*WORD_W +: WORD_W] = data_q[l];
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R6
  accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !grp_ready);

  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> grp_ready);

  // R3
  pend_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY) |=> ((pend_q & ~$past(pend_q)) == '0));

  // R3
  busy_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) |-> (serve_all != '0));

endmodule

// File: tb/sim_lane_bank_scratch.sv
module sim_lane_bank_scratch;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            grp_valid = 1'b0;
  logic            grp_ready;
  logic [NL-1:0]   grp_active = '0;
  logic [NL*10-1:0] grp_addr = '0;
  logic            rsp_done;
  logic [NL*32-1:0] rsp_data;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit finished = 0;

  typedef struct {
    int          due;
    string       tag;
    logic [31:0] word [NL];
    logic [NL-1:0] act;
  } exp_t;

  exp_t sb [$];

  lane_bank_scratch u0 (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
    .grp_active(grp_active), .grp_addr(grp_addr),
    .rsp_done(rsp_done), .rsp_data(rsp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] model_word(input logic [9:0] a);
    logic [15:0] w;
    w = {6'b0, a};
    return {w ^ 16'h5A5A, 16'(w * 16'd3)};
  endfunction

  task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  // Driver: computes the expected result, queues it, then offers the group
  task automatic run_group(input string tag, input logic [NL-1:0] act,
                           input logic [9:0] a [NL], input bit poke_busy);
    exp_t e;
    int   k;
    k = 0;
    for (int b = 0; b < 8; b++) begin
      int d;
      d = 0;
      for (int l = 0; l < NL; l++) begin
        bit dup;
        dup = 0;
        if (act[l] && a[l][2:0] == 3'(b)) begin
          for (int j = 0; j < l; j++)
            if (act[j] && a[j] == a[l]) dup = 1;
          if (!dup) d++;
        end
      end
      if (d > k) k = d;
    end
    if (k < 1) k = 1;
    e.tag = tag;
    e.act = act;
    for (int l = 0; l < NL; l++) e.word[l] = act[l] ? model_word(a[l]) : 32'h0;
    while (!grp_ready) @(negedge clk);
    e.due = cyc + 1 + k + 1;
    sb.push_back(e);
    grp_valid  = 1'b1;
    grp_active = act;
    for (int l = 0; l < NL; l++) grp_addr[l*10 +: 10] = a[l];
    @(negedge clk);
    if (poke_busy) begin
      // R6: offered while stalled, must be ignored
      grp_active = '1;
      for (int l = 0; l < NL; l++) grp_addr[l*10 +: 10] = 10'(l * 8 + 1);
      @(negedge clk);
    end
    grp_valid  = 1'b0;
    grp_active = '0;
    @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on each completion pulse
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && rsp_done) begin
        if (sb.size() == 0) begin
          check("R7 unexpected done", 256'(1), 256'(0));
        end else begin
          e = sb.pop_front();
          check({e.tag, " latency"}, 256'(cyc), 256'(e.due));
          for (int l = 0; l < NL; l++)
            check(e.act[l] ? {e.tag, " R1 R4 lane data"} : {e.tag, " R5 inactive lane"},
                  256'(rsp_data[l*32 +: 32]), 256'(e.word[l]));
          check({e.tag, " R6 ready low at done"}, 256'(grp_ready), 256'(0));
          @(negedge clk);
          check({e.tag, " R7 done single pulse"}, 256'(rsp_done), 256'(0));
          check({e.tag, " R6 ready back"}, 256'(grp_ready), 256'(1));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [9:0] a [NL];
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    check("R6 reset ready", 256'(grp_ready), 256'(1));
    check("R7 reset done", 256'(rsp_done), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);

    for (int l = 0; l < NL; l++) a[l] = 10'(l + 40);
    run_group("R2 distinct banks", 8'hFF, a, 0);
    for (int l = 0; l < NL; l++) a[l] = 10'(l * 2 + 16);
    run_group("R3 stride two", 8'hFF, a, 0);
    for (int l = 0; l < NL; l++) a[l] = 10'(l * 8 + 5);
    run_group("R3 single bank", 8'hFF, a, 0);
    for (int l = 0; l < NL; l++) a[l] = 10'd1023;
    run_group("R4 broadcast", 8'hFF, a, 0);
    a = '{10'd0, 10'd8, 10'd16, 10'd1, 10'd9, 10'd2, 10'd3, 10'd4};
    run_group("R3 three deep", 8'hFF, a, 0);
    a = '{10'd24, 10'd24, 10'd32, 10'd24, 10'd7, 10'd7, 10'd15, 10'd32};
    run_group("R4 merged in bank", 8'hFF, a, 0);
    for (int l = 0; l < NL; l++) a[l] = 10'(l * 8);
    run_group("R5 masked lanes", 8'b0100_0010, a, 0);
    run_group("R8 empty group", 8'h00, a, 0);
    for (int l = 0; l < NL; l++) a[l] = 10'(l + 200);
    run_group("R6 poke while busy", 8'hFF, a, 1);
    a = '{10'd3, 10'd11, 10'd19, 10'd27, 10'd35, 10'd43, 10'd51, 10'd59};
    run_group("R6 poke long group", 8'hFF, a, 1);

    lfsr = 16'hACE1;
    for (int g = 0; g < 24; g++) begin
      logic [NL-1:0] act;
      for (int l = 0; l < NL; l++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        a[l] = 10'(lfsr[9:0] & 10'h03F);
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      act = lfsr[7:0] | 8'h01;
      run_group("R3 random mix", act, a, 0);
    end

    while (sb.size() != 0 || !grp_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R7 all groups completed", 256'(sb.size()), 256'(0));
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule